// File: doc/BRIEF.md
# Line Protection Supervisory Controller

This block supervises one distribution line whose two ends each carry a protective device. Either device can raise a local fault-detection flag. The controller then tells other line controllers about the event with a fault broadcast. It separates temporary faults from permanent ones by watching the fault over a fixed window of millisecond ticks, and trips the breaker only when the fault outlasts that window. After a trip, the controller waits for an operator to confirm that the line can be reconnected.

A broadcast received from another line's controller puts this controller into a timed hold. While holding, it ignores local detections until the hold window ends. The millisecond tick, the distortion-peak flag, the fault-present flag and every other status flag are plain synchronous inputs. Measurement, messaging and breaker hardware lie outside the block.

Top module: `line_guard_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the controller in the idle state (state code 0) with trip and broadcast low. The state codes are: idle 0, detected 1, watching 2, isolating 3, awaiting reconnect 4, holding 5.
- R2: In idle, a high detection flag from either device moves the controller to detected on the next clock. The broadcast output is high for that first cycle in detected only.
- R3: In detected, with fault present high, a low distortion-peak flag moves the controller to watching. The fault timer keeps its count across this move.
- R4: The fault timer counts tick cycles spent in detected or watching and saturates at FAULT_LIMIT (default 100). In watching, with fault present high and the timer at its limit, the controller moves to isolating and raises trip.
- R5: A low fault-present flag in detected or watching returns the controller to idle without raising trip. Fault present takes precedence over the timer and the distortion flag.
- R6: Isolating lasts one cycle and is followed by awaiting reconnect. Trip stays high from isolating until a reconnect strobe is seen in awaiting reconnect. That strobe returns the controller to idle with trip low.
- R7: In awaiting reconnect, every input except reconnect is ignored: the state, trip and broadcast do not change.
- R8: In idle, a peer broadcast with no local detection moves the controller to holding. Holding ignores local detection and returns to idle once HOLD_LIMIT (default 100) ticks have been counted there. When a local detection and a peer broadcast arrive in the same cycle, local detection wins.
- R9: Both timers clear while the controller is idle, so each new fault episode or hold again takes the full number of ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| dev_a_det | input | 1 | Fault detection from the first device |
| dev_b_det | input | 1 | Fault detection from the second device |
| thd_peak | input | 1 | Distortion peak still present |
| fault_present | input | 1 | Fault still present on the line |
| peer_bcast | input | 1 | Fault broadcast received from a peer controller |
| reconnect | input | 1 | Operator reconnect strobe |
| trip_cmd | output | 1 | Breaker trip command |
| bcast_out | output | 1 | Fault broadcast to peer controllers |
| state_code | output | 3 | Current state code |

## Verification
The assertions treat every input as synchronous to the clock and hold for any level of it. They rely on only two things: at most one state change per clock, and a reset that is seen before the first checked edge. The stimulus changes inputs only at the falling edge. It biases the random flags so that the fault-present flag stays high for long stretches and the watching window can run out. Directed runs cover the exact tick boundary, simultaneous local and peer events, and noise applied while the controller awaits reconnect.

// File: rtl/line_guard_pkg.sv
package line_guard_pkg;

    typedef enum logic [2:0] {
        LG_IDLE     = 3'd0,
        LG_DETECTED = 3'd1,
        LG_WATCHING = 3'd2,
        LG_ISOLATE  = 3'd3,
        LG_AWAIT    = 3'd4,
        LG_HOLD     = 3'd5
    } lg_state_e;

    localparam int LG_FAULT_MS = 100;
    localparam int LG_HOLD_MS  = 100;

    typedef struct packed {
        logic local_det;
        logic thd_peak;
        logic fault_present;
        logic peer_bcast;
        logic reconnect;
    } lg_flags_t;

    function automatic logic lg_in_fault_window(lg_state_e s);
        return (s == LG_DETECTED) || (s == LG_WATCHING);
    endfunction

endpackage

// File: rtl/line_guard_timer.sv
module line_guard_timer #(
    parameter int LIMIT = 100,
    localparam int W = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         run,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic         at_limit
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (run && tick && (count != W'(LIMIT))) begin
            count <= count + 1'b1;
        end
    end

    assign at_limit = (count == W'(LIMIT));
endmodule

// File: rtl/line_guard_fsm.sv
module line_guard_fsm
    import line_guard_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lg_flags_t flags,
    input  logic      fault_done,
    input  logic      hold_done,
    output lg_state_e state,
    output logic      start_bcast,
    output logic      set_trip,
    output logic      clr_trip
);
    lg_state_e nxt;

    always_comb begin
        nxt         = state;
        start_bcast = 1'b0;
        set_trip    = 1'b0;
        clr_trip    = 1'b0;
        unique case (state)
            LG_IDLE: begin
                if (flags.local_det) begin
                    nxt         = LG_DETECTED;
                    start_bcast = 1'b1;
                end else if (flags.peer_bcast) begin
                    nxt = LG_HOLD;
                end
            end
            LG_DETECTED: begin
                if (!flags.fault_present)  nxt = LG_IDLE;
                else if (!flags.thd_peak)  nxt = LG_WATCHING;
            end
            LG_WATCHING: begin
                if (!flags.fault_present) begin
                    nxt = LG_IDLE;
                end else if (fault_done) begin
                    nxt      = LG_ISOLATE;
                    set_trip = 1'b1;
                end
            end
            LG_ISOLATE: nxt = LG_AWAIT;
            LG_AWAIT: begin
                if (flags.reconnect) begin
                    nxt      = LG_IDLE;
                    clr_trip = 1'b1;
                end
            end
            LG_HOLD: begin
                if (hold_done) nxt = LG_IDLE;
            end
            default: nxt = LG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= LG_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/line_guard_outreg.sv
module line_guard_outreg (
    input  logic clk,
    input  logic rst,
    input  logic start_bcast,
    input  logic set_trip,
    input  logic clr_trip,
    output logic trip_cmd,
    output logic bcast_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            trip_cmd  <= 1'b0;
            bcast_out <= 1'b0;
        end else begin
            bcast_out <= start_bcast;
            if (set_trip)      trip_cmd <= 1'b1;
            else if (clr_trip) trip_cmd <= 1'b0;
        end
    end
endmodule

// File: rtl/line_guard_ctrl.sv
module line_guard_ctrl
    import line_guard_pkg::*;
#(
    parameter int FAULT_LIMIT = LG_FAULT_MS,
    parameter int HOLD_LIMIT  = LG_HOLD_MS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_ms,
    input  logic       dev_a_det,
    input  logic       dev_b_det,
    input  logic       thd_peak,
    input  logic       fault_present,
    input  logic       peer_bcast,
    input  logic       reconnect,
    output logic       trip_cmd,
    output logic       bcast_out,
    output logic [2:0] state_code
);
    localparam int FW = $clog2(FAULT_LIMIT + 1);
    localparam int HW = $clog2(HOLD_LIMIT + 1);

    lg_flags_t flags;
    lg_state_e state;
    logic [FW-1:0] fault_cnt;
    logic [HW-1:0] hold_cnt;
    logic fault_done, hold_done;
    logic start_bcast, set_trip, clr_trip;

    assign flags = '{local_det:     dev_a_det | dev_b_det,
                     thd_peak:      thd_peak,
                     fault_present: fault_present,
                     peer_bcast:    peer_bcast,
                     reconnect:     reconnect};

    line_guard_timer #(.LIMIT(FAULT_LIMIT)) u_fault_tmr (
        .clk      (clk),
        .rst      (rst),
        .clear    ((state == LG_IDLE) || (state == LG_ISOLATE)),
        .run      (lg_in_fault_window(state)),
        .tick     (tick_ms),
        .count    (fault_cnt),
        .at_limit (fault_done)
    );

    line_guard_timer #(.LIMIT(HOLD_LIMIT)) u_hold_tmr (
        .clk      (clk),
        .rst      (rst),
        .clear    (state == LG_IDLE),
        .run      (state == LG_HOLD),
        .tick     (tick_ms),
        .count    (hold_cnt),
        .at_limit (hold_done)
    );

    line_guard_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .flags       (flags),
        .fault_done  (fault_done),
        .hold_done   (hold_done),
        .state       (state),
        .start_bcast (start_bcast),
        .set_trip    (set_trip),
        .clr_trip    (clr_trip)
    );

    line_guard_outreg u_out (
        .clk         (clk),
        .rst         (rst),
        .start_bcast (start_bcast),
        .set_trip    (set_trip),
        .clr_trip    (clr_trip),
        .trip_cmd    (trip_cmd),
        .bcast_out   (bcast_out)
    );

    assign state_code = state;
endmodule

// File: rtl/line_guard_chk.sv
module line_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick_ms,
    input logic       dev_a_det,
    input logic       dev_b_det,
    input logic       thd_peak,
    input logic       fault_present,
    input logic       peer_bcast,
    input logic       reconnect,
    input logic       trip_cmd,
    input logic       bcast_out,
    input logic [2:0] state_code
);
    a_r1_legal_code: assert property (@(posedge clk) disable iff (rst)
        state_code <= 3'd5);

    a_r2_bcast_single: assert property (@(posedge clk) disable iff (rst)
        bcast_out |=> !bcast_out);

    a_r2_bcast_in_detected: assert property (@(posedge clk) disable iff (rst)
        bcast_out |-> state_code == 3'd1);

    a_r5_clear_no_trip: assert property (@(posedge clk) disable iff (rst)
        ((state_code == 3'd1 || state_code == 3'd2) && !fault_present)
        |=> (state_code == 3'd0 && !trip_cmd));

    a_r6_trip_holds: assert property (@(posedge clk) disable iff (rst)
        (trip_cmd && !(state_code == 3'd4 && reconnect)) |=> trip_cmd);

    a_r6_isolate_then_await: assert property (@(posedge clk) disable iff (rst)
        state_code == 3'd3 |=> state_code == 3'd4);

    a_r7_await_sticks: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd4 && !reconnect) |=> state_code == 3'd4);

    a_r8_local_wins: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd0 && (dev_a_det || dev_b_det)) |=> state_code == 3'd1);
endmodule

bind line_guard_ctrl line_guard_chk u_chk (.*);

// File: tb/line_guard_ctrl_tb.sv
module line_guard_ctrl_tb;
    localparam int FL = 100;
    localparam int HL = 100;

    logic clk = 1'b0;
    logic rst, tick_ms, dev_a_det, dev_b_det, thd_peak, fault_present, peer_bcast, reconnect;
    logic trip_cmd, bcast_out;
    logic [2:0] state_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_st, m_ft, m_ht;
    logic m_trip, m_bc;

    always #10 clk = ~clk;

    line_guard_ctrl u_dut (
        .clk(clk), .rst(rst), .tick_ms(tick_ms), .dev_a_det(dev_a_det),
        .dev_b_det(dev_b_det), .thd_peak(thd_peak), .fault_present(fault_present),
        .peer_bcast(peer_bcast), .reconnect(reconnect), .trip_cmd(trip_cmd),
        .bcast_out(bcast_out), .state_code(state_code)
    );

    task automatic model_step();
        int ns, nf, nh;
        logic nt, nb;
        ns = m_st; nf = m_ft; nh = m_ht; nt = m_trip; nb = 1'b0;
        if (rst) begin
            ns = 0; nf = 0; nh = 0; nt = 1'b0;
        end else begin
            if (m_st == 0 || m_st == 3) nf = 0;
            else if ((m_st == 1 || m_st == 2) && tick_ms && m_ft < FL) nf = m_ft + 1;
            if (m_st == 0) nh = 0;
            else if (m_st == 5 && tick_ms && m_ht < HL) nh = m_ht + 1;
            case (m_st)
                0: if (dev_a_det || dev_b_det) begin ns = 1; nb = 1'b1; end
                   else if (peer_bcast) ns = 5;
                1: if (!fault_present) ns = 0; else if (!thd_peak) ns = 2;
                2: if (!fault_present) ns = 0;
                   else if (m_ft == FL) begin ns = 3; nt = 1'b1; end
                3: ns = 4;
                4: if (reconnect) begin ns = 0; nt = 1'b0; end
                5: if (m_ht == HL) ns = 0;
                default: ns = 0;
            endcase
        end
        m_st = ns; m_ft = nf; m_ht = nh; m_trip = nt; m_bc = nb;
    endtask

    task automatic compare(string tag);
        checks++;
        if (state_code !== 3'(m_st) || trip_cmd !== m_trip || bcast_out !== m_bc) begin
            errors++;
            $display("FAIL %s: state=%0d trip=%0b bcast=%0b expected state=%0d trip=%0b bcast=%0b",
                     tag, state_code, trip_cmd, bcast_out, m_st, m_trip, m_bc);
        end
    endtask

    // Inputs are set at the falling edge; results are sampled at the next falling edge.
    task automatic cyc(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic expect_state(string tag, int st, logic trip);
        checks++;
        if (state_code !== 3'(st) || trip_cmd !== trip) begin
            errors++;
            $display("FAIL %s: state=%0d trip=%0b expected state=%0d trip=%0b",
                     tag, state_code, trip_cmd, st, trip);
        end
    endtask

    task automatic quiet();
        tick_ms = 0; dev_a_det = 0; dev_b_det = 0; thd_peak = 1;
        fault_present = 1; peer_bcast = 0; reconnect = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        m_st = 0; m_ft = 0; m_ht = 0; m_trip = 0; m_bc = 0;
        quiet();
        rst = 1;
        @(negedge clk);
        cyc("R1 reset");
        cyc("R1 reset");
        expect_state("R1 reset idle", 0, 1'b0);
        rst = 0;

        // Permanent fault: detect, peak stays for 5 ticks, then watch to the limit.
        dev_a_det = 1;
        cyc("R2 detect from device A");
        dev_a_det = 0;
        expect_state("R2 detected", 1, 1'b0);
        tick_ms = 1;
        for (int i = 0; i < 5; i++) cyc("R3 peak present");
        thd_peak = 0;
        cyc("R3 move to watching");
        expect_state("R3 watching", 2, 1'b0);
        for (int i = 0; i < 93; i++) cyc("R4 watching window");
        expect_state("R4 still watching before limit", 2, 1'b0);
        for (int i = 0; i < 3; i++) cyc("R4 limit reached");
        expect_state("R6 awaiting after isolate", 4, 1'b1);
        // Noise while awaiting reconnect.
        dev_b_det = 1; peer_bcast = 1; fault_present = 0; thd_peak = 1;
        for (int i = 0; i < 20; i++) cyc("R7 await ignores inputs");
        expect_state("R7 still awaiting", 4, 1'b1);
        quiet();
        reconnect = 1;
        cyc("R6 reconnect");
        reconnect = 0;
        expect_state("R6 back to idle, trip low", 0, 1'b0);

        // Temporary fault from device B, cleared during watching.
        dev_b_det = 1; tick_ms = 1;
        cyc("R2 detect from device B");
        dev_b_det = 0; thd_peak = 0;
        for (int i = 0; i < 50; i++) cyc("R3 watching");
        fault_present = 0;
        cyc("R5 fault clears");
        expect_state("R5 idle no trip", 0, 1'b0);
        quiet();

        // Clear during detected.
        dev_a_det = 1;
        cyc("R2 detect");
        dev_a_det = 0; fault_present = 0;
        cyc("R5 clear in detected");
        quiet();

        // Second episode needs the full window again.
        dev_a_det = 1; tick_ms = 1;
        cyc("R9 new episode");
        dev_a_det = 0; thd_peak = 0;
        for (int i = 0; i < 99; i++) cyc("R9 full window");
        expect_state("R9 not yet isolated", 2, 1'b0);
        cyc("R9 limit");
        cyc("R9 isolate");
        expect_state("R9 isolated", 3, 1'b1);
        quiet();
        cyc("R6 await");
        reconnect = 1;
        cyc("R6 reconnect");
        quiet();

        // Peer broadcast and simultaneous arrival.
        peer_bcast = 1; dev_a_det = 1;
        cyc("R8 local wins over peer");
        expect_state("R8 detected", 1, 1'b0);
        quiet(); fault_present = 0;
        cyc("R5 back to idle");
        quiet();
        peer_bcast = 1;
        cyc("R8 enter hold");
        peer_bcast = 0; dev_a_det = 1; tick_ms = 1;
        for (int i = 0; i < 100; i++) cyc("R8 hold ignores local");
        expect_state("R8 still holding", 5, 1'b0);
        cyc("R8 hold ends");
        dev_a_det = 0;
        expect_state("R8 idle after hold", 0, 1'b0);

        // Random phase with biased flags.
        for (int i = 0; i < 6000; i++) begin
            tick_ms       = ($urandom % 4) != 0;
            dev_a_det     = ($urandom % 40) == 0;
            dev_b_det     = ($urandom % 40) == 0;
            thd_peak      = ($urandom % 8) == 0;
            fault_present = ($urandom % 200) != 0;
            peer_bcast    = ($urandom % 60) == 0;
            reconnect     = ($urandom % 30) == 0;
            rst           = ($urandom % 3000) == 0;
            cyc("random mix");
        end
        rst = 0;
        finish_run();
    end
endmodule